// File: doc/BRIEF.md
# Frame-Buffer Line Address Generator

This block walks a frame stored in system memory and produces, for every line to be read, a descriptor holding the 48-bit byte start address, the line length in bytes and a plane tag. It handles single-plane packed pixel formats and two-plane 4:2:0 formats. In the two-plane formats, a luma plane of one byte per pixel sits beside an interleaved chroma plane of two bytes per Cb/Cr pair. Each plane has its own base address and its own signed row skip. The skip is added after every line, so a rectangle inside a larger buffer can be read line by line, or whole lines can be passed over.

Software sets the configuration inputs and pulses `start`. The block then captures everything it needs, selects the even-field or odd-field pair of base addresses, and hands out descriptors over a valid/ready handshake until the frame is done. A width that cannot be fetched raises an error flag, and the frame produces no descriptors.

Top module: `fb_line_addr_gen`

## Requirements
- R1: After reset, `desc_valid`, `busy` and `cfg_err` are all 0.
- R2: Luma/main line k (counting from 0) starts at byte address B + k·(L + S) modulo 2^48. B is {ext, base} of the selected field, L is the line length in bytes, and S is `cfg_row_skip` read as a signed 32-bit value.
- R3: The line length is width × bytes-per-pixel. For `cfg_fmt` 0 (packed) and 3 (treated as packed) the byte count is `cfg_pix_size`+1. For `cfg_fmt` 1 (4:2:2) it is 2. For `cfg_fmt` 2 (two-plane 4:2:0) the luma plane uses 1.
- R4: In two-plane mode, chroma line j starts at Bc + j·(Lc + Sc) modulo 2^48. Lc is the width rounded up to an even number, and Sc is `cfg_row_skip_c` (signed). The frame holds floor(lines/2) chroma lines, tagged `desc_chroma`=1.
- R5: Descriptor order is luma lines in ascending order, with one chroma line inserted after every second luma line. A frame emits exactly its expected number of descriptors, after which `busy` and `desc_valid` fall.
- R6: `cfg_field`=0 selects the 0-numbered main and chroma bases and extensions. `cfg_field`=1 selects the 1-numbered set.
- R7: A start with width 0, or with an odd width in 4:2:2 mode, sets `cfg_err` and emits no descriptors. The next start with a valid configuration clears `cfg_err`.
- R8: While `desc_valid` is 1 and `desc_ready` is 0, the address, length and plane tag hold steady.
- R9: A `start` pulse while `busy` is 1 has no effect on the running frame, and configuration changes during a frame have none either.
- R10: A valid start with a line count of 0 emits no descriptors and leaves `busy` at 0.
- R11: A negative row skip or a base near the top of the 48-bit space wraps modulo 2^48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fmt | input | 2 | 0 packed, 1 4:2:2, 2 two-plane 4:2:0, 3 packed |
| cfg_pix_size | input | 2 | Packed bytes per pixel minus one |
| cfg_width | input | 13 | Line width in pixels |
| cfg_lines | input | 12 | Luma/main line count |
| cfg_row_skip | input | 32 | Signed byte skip after each main line |
| cfg_row_skip_c | input | 32 | Signed byte skip after each chroma line |
| cfg_field | input | 1 | Field select: 0 even, 1 odd |
| cfg_base_main0 | input | 32 | Main base low bits, field 0 |
| cfg_ext_main0 | input | 16 | Main base upper bits, field 0 |
| cfg_base_main1 | input | 32 | Main base low bits, field 1 |
| cfg_ext_main1 | input | 16 | Main base upper bits, field 1 |
| cfg_base_chroma0 | input | 32 | Chroma base low bits, field 0 |
| cfg_ext_chroma0 | input | 16 | Chroma base upper bits, field 0 |
| cfg_base_chroma1 | input | 32 | Chroma base low bits, field 1 |
| cfg_ext_chroma1 | input | 16 | Chroma base upper bits, field 1 |
| start | input | 1 | Frame start pulse |
| desc_ready | input | 1 | Consumer accepts descriptor |
| desc_valid | output | 1 | Descriptor available |
| desc_addr | output | 48 | Line start byte address |
| desc_len | output | 15 | Line length in bytes |
| desc_chroma | output | 1 | 1 for a chroma-plane line |
| busy | output | 1 | Frame in progress |
| cfg_err | output | 1 | Last start had an unusable width |

## Verification
The stability assertion assumes that `desc_ready` is the only signal able to release a pending descriptor, and that a start arriving during a frame is dropped. The bench keeps to this: it changes configuration and pulses `start` only at negative clock edges, and it does both in the middle of a stalled frame to show that neither disturbs the output. The ordering and count assertions take for granted that a captured line count stays fixed for the whole frame. The bench therefore checks every frame to its last descriptor before it changes the line count.

// File: rtl/fb_line_addr_pkg.sv
package fb_line_addr_pkg;

  typedef enum logic [1:0] {
    FMT_PACKED = 2'd0,
    FMT_YUV422 = 2'd1,
    FMT_SEMI420 = 2'd2,
    FMT_PACKED_ALT = 2'd3
  } pix_fmt_e;

  // bytes per pixel for the main/luma plane
  function automatic logic [2:0] main_bytes_per_px(input logic [1:0] fmt, input logic [1:0] sz);
    case (fmt)
      FMT_YUV422:  return 3'd2;
      FMT_SEMI420: return 3'd1;
      default:     return {1'b0, sz} + 3'd1;
    endcase
  endfunction

  // distance between consecutive line starts, modulo 2^48
  function automatic logic [47:0] line_pitch(input logic [31:0] len, input logic [31:0] skip);
    return {16'b0, len} + {{16{skip[31]}}, skip};
  endfunction

  // unusable geometry check
  function automatic logic width_bad(input logic [1:0] fmt, input logic [31:0] w);
    return (w == 32'd0) || (fmt == FMT_YUV422 && w[0]);
  endfunction

endpackage

// File: rtl/fb_line_addr_ptr.sv
module fb_line_addr_ptr #(
  parameter int AW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] step,
  input  logic          adv,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      step_q <= '0;
    end else if (load) begin
      addr   <= base;
      step_q <= step;
    end else if (adv) begin
      addr <= addr + step_q;
    end
  end
endmodule

// File: rtl/fb_line_addr_seq.sv
module fb_line_addr_seq #(
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cfg_bad,
  input  logic          two_plane,
  input  logic [LW-1:0] lines,
  input  logic          desc_ready,
  output logic          desc_valid,
  output logic          plane_c,
  output logic          busy,
  output logic          err,
  output logic          load,
  output logic          adv_y,
  output logic          adv_c
);
  logic          busy_q, plane_q, err_q, two_q;
  logic [LW-1:0] ycnt, lines_q, ynext;
  logic          fire;

  assign load  = start && !busy_q;
  assign fire  = busy_q && desc_ready;
  assign ynext = ycnt + 1'b1;
  assign adv_y = fire && !plane_q;
  assign adv_c = fire && plane_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      plane_q <= 1'b0;
      err_q   <= 1'b0;
      two_q   <= 1'b0;
      ycnt    <= '0;
      lines_q <= '0;
    end else if (load) begin
      err_q   <= cfg_bad;
      busy_q  <= !cfg_bad && (lines != '0);
      two_q   <= two_plane;
      lines_q <= lines;
      ycnt    <= '0;
      plane_q <= 1'b0;
    end else if (fire) begin
      if (!plane_q) begin
        ycnt <= ynext;
        if (two_q && !ynext[0]) plane_q <= 1'b1;
        else if (ynext == lines_q) busy_q <= 1'b0;
      end else begin
        plane_q <= 1'b0;
        if (ycnt == lines_q) busy_q <= 1'b0;
      end
    end
  end

  assign desc_valid = busy_q;
  assign plane_c    = plane_q;
  assign busy       = busy_q;
  assign err        = err_q;

  // R5
  chroma_then_luma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && plane_q) |=> !plane_c);
  // R5
  luma_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !plane_q) |-> (ycnt < lines_q));
  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !desc_valid);
  // R4
  chroma_only_two_plane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && plane_c) |-> two_q);
endmodule

// File: rtl/fb_line_addr_gen.sv
module fb_line_addr_gen
  import fb_line_addr_pkg::*;
#(
  parameter int WW    = 13,
  parameter int LW    = 12,
  parameter int LO_W  = 32,
  parameter int EXT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               cfg_fmt,
  input  logic [1:0]               cfg_pix_size,
  input  logic [WW-1:0]            cfg_width,
  input  logic [LW-1:0]            cfg_lines,
  input  logic [31:0]              cfg_row_skip,
  input  logic [31:0]              cfg_row_skip_c,
  input  logic                     cfg_field,
  input  logic [LO_W-1:0]          cfg_base_main0,
  input  logic [EXT_W-1:0]         cfg_ext_main0,
  input  logic [LO_W-1:0]          cfg_base_main1,
  input  logic [EXT_W-1:0]         cfg_ext_main1,
  input  logic [LO_W-1:0]          cfg_base_chroma0,
  input  logic [EXT_W-1:0]         cfg_ext_chroma0,
  input  logic [LO_W-1:0]          cfg_base_chroma1,
  input  logic [EXT_W-1:0]         cfg_ext_chroma1,
  input  logic                     start,
  input  logic                     desc_ready,
  output logic                     desc_valid,
  output logic [LO_W+EXT_W-1:0]    desc_addr,
  output logic [WW+1:0]            desc_len,
  output logic                     desc_chroma,
  output logic                     busy,
  output logic                     cfg_err
);
  localparam int AW   = LO_W + EXT_W;
  localparam int LENW = WW + 2;

  logic [31:0]     ylen_w, clen_w;
  logic [LENW-1:0] ylen_q, clen_q;
  logic            load, adv_y, adv_c, bad, two_plane;
  logic [AW-1:0]   base_sel [2];
  logic [AW-1:0]   step_sel [2];
  logic [AW-1:0]   addr_p   [2];
  logic            adv_p    [2];

  assign ylen_w    = 32'(cfg_width) * 32'(main_bytes_per_px(cfg_fmt, cfg_pix_size));
  assign clen_w    = 32'(cfg_width) + 32'(cfg_width[0]);
  assign bad       = width_bad(cfg_fmt, 32'(cfg_width));
  assign two_plane = (cfg_fmt == FMT_SEMI420);

  assign base_sel[0] = cfg_field ? {cfg_ext_main1, cfg_base_main1} : {cfg_ext_main0, cfg_base_main0};
  assign base_sel[1] = cfg_field ? {cfg_ext_chroma1, cfg_base_chroma1} : {cfg_ext_chroma0, cfg_base_chroma0};
  assign step_sel[0] = AW'(line_pitch(ylen_w, cfg_row_skip));
  assign step_sel[1] = AW'(line_pitch(clen_w, cfg_row_skip_c));
  assign adv_p[0]    = adv_y;
  assign adv_p[1]    = adv_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ylen_q <= '0;
      clen_q <= '0;
    end else if (load) begin
      ylen_q <= ylen_w[LENW-1:0];
      clen_q <= clen_w[LENW-1:0];
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_plane
    fb_line_addr_ptr #(.AW(AW)) u_ptr (
      .clk  (clk),
      .rst_n(rst_n),
      .load (load),
      .base (base_sel[p]),
      .step (step_sel[p]),
      .adv  (adv_p[p]),
      .addr (addr_p[p])
    );
  end

  fb_line_addr_seq #(.LW(LW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cfg_bad   (bad),
    .two_plane (two_plane),
    .lines     (cfg_lines),
    .desc_ready(desc_ready),
    .desc_valid(desc_valid),
    .plane_c   (desc_chroma),
    .busy      (busy),
    .err       (cfg_err),
    .load      (load),
    .adv_y     (adv_y),
    .adv_c     (adv_c)
  );

  assign desc_addr = desc_chroma ? addr_p[1] : addr_p[0];
  assign desc_len  = desc_chroma ? clen_q : ylen_q;

  // R8
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !desc_ready) |=>
      ($stable(desc_addr) && $stable(desc_len) && $stable(desc_chroma) && desc_valid));
  // R9
  no_restart_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |-> !load);
endmodule

// File: tb/fb_line_addr_gen_bench.sv
module fb_line_addr_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam longint MASK48 = 64'h0000_FFFF_FFFF_FFFF;
  localparam longint BM0 = 64'h0012_0000_1000;
  localparam longint BM1 = 64'hFFFF_FFFF_FFF0;
  localparam longint BC0 = 64'h0034_0040_0000;
  localparam longint BC1 = 64'h0034_0050_0000;

  typedef struct packed {
    logic [1:0]  fmt;
    logic [1:0]  pix;
    logic [12:0] w;
    logic [11:0] lines;
    logic [31:0] ri;
    logic [31:0] ric;
    logic        fld;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd3, 13'd16, 12'd3, 32'd0,          32'd0,  1'b0},  // R2 R3 4-byte
    '{2'd0, 2'd0, 13'd10, 12'd4, 32'd6,          32'd0,  1'b0},  // R2 1-byte skip
    '{2'd0, 2'd2, 13'd8,  12'd3, -32'sd48,       32'd0,  1'b0},  // R11 negative
    '{2'd1, 2'd0, 13'd6,  12'd3, 32'd4,          32'd0,  1'b1},  // R6 R11 wrap 4:2:2
    '{2'd2, 2'd0, 13'd10, 12'd5, 32'd2,          -32'sd4, 1'b0}, // R4 R5
    '{2'd2, 2'd1, 13'd7,  12'd4, 32'd0,          32'd8,  1'b1},  // R4 R6 odd width
    '{2'd3, 2'd1, 13'd5,  12'd1, 32'd0,          32'd0,  1'b0}   // R3 fmt 3
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_fmt = '0, cfg_pix_size = '0;
  logic [12:0] cfg_width = '0;
  logic [11:0] cfg_lines = '0;
  logic [31:0] cfg_row_skip = '0, cfg_row_skip_c = '0;
  logic cfg_field = 1'b0, start = 1'b0, desc_ready = 1'b0;
  logic desc_valid, desc_chroma, busy, cfg_err;
  logic [47:0] desc_addr;
  logic [14:0] desc_len;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fb_line_addr_gen u_fb_line_addr_gen (
    .clk(clk), .rst_n(rst_n),
    .cfg_fmt(cfg_fmt), .cfg_pix_size(cfg_pix_size), .cfg_width(cfg_width),
    .cfg_lines(cfg_lines), .cfg_row_skip(cfg_row_skip), .cfg_row_skip_c(cfg_row_skip_c),
    .cfg_field(cfg_field),
    .cfg_base_main0(BM0[31:0]), .cfg_ext_main0(BM0[47:32]),
    .cfg_base_main1(BM1[31:0]), .cfg_ext_main1(BM1[47:32]),
    .cfg_base_chroma0(BC0[31:0]), .cfg_ext_chroma0(BC0[47:32]),
    .cfg_base_chroma1(BC1[31:0]), .cfg_ext_chroma1(BC1[47:32]),
    .start(start), .desc_ready(desc_ready), .desc_valid(desc_valid),
    .desc_addr(desc_addr), .desc_len(desc_len), .desc_chroma(desc_chroma),
    .busy(busy), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    cfg_fmt = v.fmt; cfg_pix_size = v.pix; cfg_width = v.w; cfg_lines = v.lines;
    cfg_row_skip = v.ri; cfg_row_skip_c = v.ric; cfg_field = v.fld;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // wait for a descriptor, compare it, let it be taken
  task automatic expect_desc(input string req, input longint a, input int len, input bit chroma);
    int n = 0;
    while (!desc_valid && n < 20) begin @(negedge clk); n++; end
    check({req, " valid"}, longint'(desc_valid), 1);
    check({req, " addr"}, longint'(desc_addr), a & MASK48);
    check({req, " len"}, longint'(desc_len), longint'(len));
    check({req, " plane"}, longint'(desc_chroma), longint'(chroma));
    @(negedge clk);
  endtask

  // expected frame computed from the requirements; stall adds R8/R9 stimulus
  task automatic run_frame(input vec_t v, input bit stall);
    int bpp, ylen, clen, jc;
    longint yb, cb;
    bpp  = (v.fmt == 2'd1) ? 2 : (v.fmt == 2'd2) ? 1 : int'(v.pix) + 1;
    ylen = int'(v.w) * bpp;
    clen = (int'(v.w) % 2 == 1) ? int'(v.w) + 1 : int'(v.w);
    yb   = v.fld ? BM1 : BM0;
    cb   = v.fld ? BC1 : BC0;
    desc_ready = !stall;
    apply(v);
    if (stall) begin
      logic [47:0] a0; logic [14:0] l0;
      a0 = desc_addr; l0 = desc_len;
      cfg_lines = 12'd9; cfg_width = 13'd3; start = 1'b1;
      @(negedge clk); start = 1'b0;
      @(negedge clk); @(negedge clk);
      check("R8 stall addr", longint'(desc_addr), longint'(a0));
      check("R8 stall len", longint'(desc_len), longint'(l0));
      cfg_lines = v.lines; cfg_width = v.w;
      desc_ready = 1'b1;
    end
    jc = 0;
    for (int k = 0; k < int'(v.lines); k++) begin
      expect_desc("R2 R3 R5 R6 R11 luma", yb + longint'(k) * (longint'(ylen) + longint'($signed(v.ri))), ylen, 1'b0);
      if (v.fmt == 2'd2 && (k % 2) == 1) begin
        expect_desc("R4 R5 chroma", cb + longint'(jc) * (longint'(clen) + longint'($signed(v.ric))), clen, 1'b1);
        jc++;
      end
    end
    check("R5 end busy", longint'(busy), 0);
    check("R5 end valid", longint'(desc_valid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R1 valid", longint'(desc_valid), 0);
    check("R1 busy", longint'(busy), 0);
    check("R1 err", longint'(cfg_err), 0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);

    for (int i = 0; i < NV; i++) run_frame(VECS[i], 1'b0);

    // R7 zero width
    desc_ready = 1'b1;
    apply('{2'd0, 2'd0, 13'd0, 12'd4, 32'd0, 32'd0, 1'b0});
    check("R7 err zero width", longint'(cfg_err), 1);
    repeat (3) @(negedge clk);
    check("R7 no desc", longint'(desc_valid), 0);
    // R7 odd 4:2:2 width
    apply('{2'd1, 2'd0, 13'd5, 12'd2, 32'd0, 32'd0, 1'b0});
    check("R7 err odd 422", longint'(cfg_err), 1);
    check("R7 no desc 422", longint'(busy), 0);
    // R7 cleared by good frame
    run_frame(VECS[1], 1'b0);
    check("R7 err cleared", longint'(cfg_err), 0);

    // R10 zero lines
    apply('{2'd0, 2'd0, 13'd4, 12'd0, 32'd0, 32'd0, 1'b0});
    repeat (2) @(negedge clk);
    check("R10 busy", longint'(busy), 0);
    check("R10 valid", longint'(desc_valid), 0);

    // R8 R9 stall with restart attempt
    run_frame(VECS[4], 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule